// File: doc/BRIEF.md
# Memory Access Unit with Locked Atomic Add

This unit carries out the memory-touching instructions of a 64-bit register machine whose 8-bit opcode packs an access class, an access size and an addressing mode. It accepts one instruction at a time through a valid/ready input stream that carries the opcode, the two operand register values, a 16-bit signed displacement and a 32-bit immediate. It turns each instruction into requests on a byte-addressed, 64-bit-wide memory port with per-byte strobes. It reports one result per instruction on a valid/ready output stream. A load's result is the zero-extended data for the destination register. A store or atomic returns zero. An instruction the unit does not support returns an illegal flag.

The supported forms are a register load, a register store, an immediate store and a fetch-free atomic add. The atomic add reads the memory operand, adds the source register and writes the sum back. The lock output stays high from the read request until the write is granted, so the memory side can keep other masters out. Back-pressure rules: the input side presents `in_ready` only while no instruction is in flight. An instruction is taken in the cycle where `in_valid` and `in_ready` are both high. A result stays on the output, unchanged, until `out_ready` is seen high while `out_valid` is high. On the memory side, a request holds all of its fields until `mem_gnt` is high in the same cycle. Read data is taken in the cycle where `mem_rvalid` is high, which must come after the grant cycle.

Top module: `ldst_unit`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `mem_req` and `mem_lock` are 0 and `in_ready` is 1.
- R2: The opcode is decoded as class = bits 2..0, size = bits 4..3, mode = bits 7..5. The legal forms are:
  - class 1 (register load) in mode 3;
  - class 2 (immediate store) in mode 3;
  - class 3 (register store) in mode 3;
  - class 3 in mode 6 with immediate 0 (atomic add), only for size codes 0 and 3.
  Every other combination returns `out_illegal`=1 with `out_data`=0 and makes no memory request.
- R3: The byte address is the base register plus the sign-extended 16-bit displacement, reduced modulo 2^ADDR_W. The base is the source operand for loads and the destination operand for stores and the atomic add.
- R4: A register store writes the low N bytes of the source operand at the address, where N is 4, 2, 1 or 8 for size codes 0, 1, 2 and 3. Byte k goes to lane (address mod 8)+k. The strobes are set only on those lanes, and no other memory byte changes.
- R5: An immediate store writes the low N bytes of the immediate, after the immediate is sign-extended to 64 bits.
- R6: A load returns the N bytes at the address in `out_data`, zero-extended to 64 bits, with `out_illegal`=0.
- R7: The atomic add replaces the memory operand with (old value + source operand) modulo 2^(8N). It issues exactly one read and one write, both with `mem_lock`=1, and keeps `mem_lock` high between them. Its `out_data` is 0. No other instruction raises `mem_lock`.
- R8: An otherwise legal access whose address is not a multiple of N is illegal under the rule of R2.
- R9: `in_ready` is high only when no instruction is in flight. Every accepted instruction produces exactly one result, and that result is held stable while `out_ready` is low.
- R10: A memory request keeps its address, write flag, strobes and write data stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_opcode | input | 8 | Packed class, size and mode |
| in_dst | input | 64 | Destination operand register value |
| in_src | input | 64 | Source operand register value |
| in_disp | input | 16 | Signed displacement |
| in_imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Load data, zero-extended; 0 otherwise |
| out_illegal | output | 1 | Instruction was not supported |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Indivisible sequence in progress |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 8 | Byte strobes |
| mem_wdata | output | 64 | Write data placed on its lanes |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 64 | Read data, whole 64-bit word |

## Verification
The bench builds the unit with ADDR_W=8, so the whole address space is a 256-byte memory that the bench can mirror byte for byte. In that space, negative displacements and dropped high base bits wrap into addresses the bench can check. It sweeps all 256 opcodes and every size at all eight byte offsets for each supported form. This reaches every legal and illegal encoding and every lane placement and misalignment, and it ends by reading back the whole memory. Grants are withheld in a repeating pattern and the result side is stalled, so the hold rules of the two handshakes are exercised.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int XLEN   = 64;
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);

  localparam logic [2:0] CLS_LOADX  = 3'd1;
  localparam logic [2:0] CLS_STIMM  = 3'd2;
  localparam logic [2:0] CLS_STREG  = 3'd3;
  localparam logic [2:0] MODE_PLAIN = 3'd3;
  localparam logic [2:0] MODE_LOCK  = 3'd6;
  localparam logic [31:0] LOCK_OP_ADD = 32'h0;

  typedef enum logic [1:0] {SZ_WORD = 2'd0, SZ_HALF = 2'd1, SZ_BYTE = 2'd2, SZ_DWORD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {K_LOAD, K_STORE, K_ATOMIC, K_NONE} acc_kind_e;

  function automatic logic [3:0] size_bytes(acc_size_e s);
    case (s)
      SZ_WORD: return 4'd4;
      SZ_HALF: return 4'd2;
      SZ_BYTE: return 4'd1;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [7:0]        opcode,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  input  logic [15:0]       disp,
  input  logic [31:0]       imm,
  output acc_kind_e         kind,
  output acc_size_e         size,
  output logic [ADDR_W-1:0] addr,
  output logic [XLEN-1:0]   store_val,
  output logic              bad
);
  logic [2:0]      cls, mode;
  logic [XLEN-1:0] base, ea_full, disp_ext;
  logic [3:0]      nbytes;
  logic            misaligned;

  assign cls      = opcode[2:0];
  assign mode     = opcode[7:5];
  assign size     = acc_size_e'(opcode[4:3]);
  assign nbytes   = size_bytes(size);
  assign disp_ext = {{(XLEN-16){disp[15]}}, disp};

  always_comb begin
    kind = K_NONE;
    if (mode == MODE_PLAIN && cls == CLS_LOADX) kind = K_LOAD;
    else if (mode == MODE_PLAIN && (cls == CLS_STIMM || cls == CLS_STREG)) kind = K_STORE;
    else if (mode == MODE_LOCK && cls == CLS_STREG && imm == LOCK_OP_ADD &&
             (size == SZ_WORD || size == SZ_DWORD)) kind = K_ATOMIC;
  end

  assign base    = (kind == K_LOAD) ? src_val : dst_val;
  assign ea_full = base + disp_ext;
  assign addr    = ea_full[ADDR_W-1:0];

  assign store_val = (cls == CLS_STIMM) ? {{(XLEN-32){imm[31]}}, imm} : src_val;

  assign misaligned = (({1'b0, addr[LANE_W-1:0]}) & (nbytes - 4'd1)) != 4'd0;
  assign bad        = (kind == K_NONE) || misaligned;
endmodule

// File: rtl/ldst_lane.sv
module ldst_lane
  import ldst_pkg::*;
(
  input  logic [LANE_W-1:0] lane_lo,
  input  acc_size_e         size,
  input  logic [XLEN-1:0]   wval,
  input  logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   wdata,
  output logic [LANES-1:0]  be,
  output logic [XLEN-1:0]   rval
);
  logic [3:0]      nbytes;
  logic [XLEN-1:0] w_shift, r_shift;
  logic [3:0]      hi_lane;

  assign nbytes  = size_bytes(size);
  assign hi_lane = {1'b0, lane_lo} + nbytes;
  assign w_shift = wval << {lane_lo, 3'b000};
  assign r_shift = rdata >> {lane_lo, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [3:0] IDX = 4'(i);
    assign be[i]           = (IDX >= {1'b0, lane_lo}) && (IDX < hi_lane);
    assign wdata[8*i +: 8] = be[i] ? w_shift[8*i +: 8] : 8'h00;
    assign rval[8*i +: 8]  = (IDX < nbytes) ? r_shift[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/ldst_amo_add.sv
module ldst_amo_add
  import ldst_pkg::*;
(
  input  acc_size_e       size,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] addend,
  output logic [XLEN-1:0] sum
);
  logic [31:0] sum32;
  assign sum32 = old_val[31:0] + addend[31:0];
  assign sum   = (size == SZ_DWORD) ? (old_val + addend) : {{(XLEN-32){1'b0}}, sum32};
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [63:0]       in_dst,
  input  logic [63:0]       in_src,
  input  logic [15:0]       in_disp,
  input  logic [31:0]       in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic              out_illegal,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_RWAIT, S_AMO_WR, S_RESP} state_e;

  state_e            st;
  acc_kind_e         d_kind, r_kind;
  acc_size_e         d_size, r_size;
  logic [ADDR_W-1:0] d_addr, r_addr;
  logic [XLEN-1:0]   d_wval, r_wval, r_old, r_data;
  logic              d_bad, r_illegal;
  logic [XLEN-1:0]   lane_wval, lane_rval, amo_sum;

  ldst_decode #(.ADDR_W(ADDR_W)) u_dec (
    .opcode(in_opcode), .dst_val(in_dst), .src_val(in_src), .disp(in_disp), .imm(in_imm),
    .kind(d_kind), .size(d_size), .addr(d_addr), .store_val(d_wval), .bad(d_bad)
  );

  ldst_amo_add u_add (.size(r_size), .old_val(r_old), .addend(r_wval), .sum(amo_sum));

  assign lane_wval = (st == S_AMO_WR) ? amo_sum : r_wval;

  ldst_lane u_lane (
    .lane_lo(r_addr[LANE_W-1:0]), .size(r_size), .wval(lane_wval), .rdata(mem_rdata),
    .wdata(mem_wdata), .be(mem_be), .rval(lane_rval)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      r_kind    <= K_NONE;
      r_size    <= SZ_WORD;
      r_addr    <= '0;
      r_wval    <= '0;
      r_old     <= '0;
      r_data    <= '0;
      r_illegal <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          r_kind    <= d_kind;
          r_size    <= d_size;
          r_addr    <= d_addr;
          r_wval    <= d_wval;
          r_data    <= '0;
          r_illegal <= d_bad;
          st        <= d_bad ? S_RESP : S_ISSUE;
        end
        S_ISSUE: if (mem_gnt) st <= (r_kind == K_STORE) ? S_RESP : S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          if (r_kind == K_ATOMIC) begin
            r_old <= lane_rval;
            st    <= S_AMO_WR;
          end else begin
            r_data <= lane_rval;
            st     <= S_RESP;
          end
        end
        S_AMO_WR: if (mem_gnt) st <= S_RESP;
        S_RESP:   if (out_ready) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign in_ready    = (st == S_IDLE);
  assign out_valid   = (st == S_RESP);
  assign out_data    = r_data;
  assign out_illegal = r_illegal;
  assign mem_req     = (st == S_ISSUE) || (st == S_AMO_WR);
  assign mem_we      = (st == S_AMO_WR) || (st == S_ISSUE && r_kind == K_STORE);
  assign mem_lock    = (r_kind == K_ATOMIC) && (st == S_ISSUE || st == S_RWAIT || st == S_AMO_WR);
  assign mem_addr    = r_addr;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_be) && $stable(mem_wdata));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_illegal));

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid && !mem_req && !mem_lock);

  a_r7_lock_span: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_lock && !mem_we |=> mem_lock);

  a_r7_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> $past(mem_req && mem_gnt && mem_we));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4 || $countones(mem_be) == 8));

  a_r2_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !mem_req && !mem_lock && out_data == 64'd0);
endmodule

// File: tb/ldst_unit_tb.sv
`timescale 1ns/1ps
module ldst_unit_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]    in_opcode = '0;
  logic [63:0]   in_dst = '0, in_src = '0;
  logic [15:0]   in_disp = '0;
  logic [31:0]   in_imm = '0;
  logic          in_ready, out_valid, out_illegal;
  logic [63:0]   out_data;
  logic          mem_req, mem_gnt, mem_we, mem_lock, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_be;
  logic [63:0]   mem_wdata, mem_rdata;

  ldst_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
    .in_dst(in_dst), .in_src(in_src), .in_disp(in_disp), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_byte(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  logic [63:0] mem [0:31];
  logic [7:0]  refm [0:255];
  logic [7:0]  gcnt;
  int          req_cyc = 0, lk_rd = 0, lk_wr = 0, cyc = 0;

  assign mem_gnt = mem_req && (gcnt[1:0] != 2'd1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      gcnt       <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      for (int w = 0; w < 32; w++)
        for (int b = 0; b < 8; b++) mem[w][8*b +: 8] <= init_byte(8*w + b);
    end else begin
      gcnt       <= gcnt + 8'd1;
      mem_rvalid <= 1'b0;
      if (mem_req) req_cyc <= req_cyc + 1;
      if (mem_req && mem_gnt) begin
        if (mem_lock && mem_we)  lk_wr <= lk_wr + 1;
        if (mem_lock && !mem_we) lk_rd <= lk_rd + 1;
        if (mem_we) begin
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[7:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
          mem_rdata  <= mem[mem_addr[7:3]];
          mem_rvalid <= 1'b1;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                        input logic [15:0] o, input logic [31:0] im, input int stall);
    int nb, addr, rq0, lr0, lw0;
    bit ld, sti, str, amo, legal;
    logic [63:0] base, val, exp_data, old, sum, a_data;
    logic a_ill;
    nb  = (op[4:3] == 2'd0) ? 4 : (op[4:3] == 2'd1) ? 2 : (op[4:3] == 2'd2) ? 1 : 8;
    ld  = (op[2:0] == 3'd1) && (op[7:5] == 3'd3);
    sti = (op[2:0] == 3'd2) && (op[7:5] == 3'd3);
    str = (op[2:0] == 3'd3) && (op[7:5] == 3'd3);
    amo = (op[2:0] == 3'd3) && (op[7:5] == 3'd6) && (im == 32'd0) && (nb == 4 || nb == 8);
    base = ld ? s : d;
    addr = int'((base + {{48{o[15]}}, o}) & 64'hFF);
    legal = (ld || sti || str || amo) && (addr % nb == 0);
    exp_data = '0;
    if (legal) begin
      old = '0;
      for (int k = 0; k < nb; k++) old[8*k +: 8] = refm[addr + k];
      if (ld) exp_data = old;
      val = sti ? {{32{im[31]}}, im} : s;
      sum = (nb == 8) ? old + s : {32'd0, old[31:0] + s[31:0]};
      if (amo) val = sum;
      if (!ld) for (int k = 0; k < nb; k++) refm[addr + k] = val[8*k +: 8];
    end
    rq0 = req_cyc; lr0 = lk_rd; lw0 = lk_wr;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_opcode = op; in_dst = d; in_src = s; in_disp = o; in_imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R9 busy after accept", 64'(in_ready), 64'd0);
    while (!out_valid) @(negedge clk);
    a_data = out_data; a_ill = out_illegal;
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk(out_valid && out_data == a_data && out_illegal == a_ill, "R9 result held under stall",
          out_data, a_data);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R9 single result", 64'(out_valid), 64'd0);
    chk(a_ill == !legal, (addr % nb != 0) ? "R8 misaligned flag" : "R2 illegal flag",
        64'(a_ill), 64'(!legal));
    chk(a_data == exp_data, ld ? "R6 load data zero-extended" : "R2 R7 non-load data zero",
        a_data, exp_data);
    if (!legal) chk(req_cyc == rq0, "R2 no request when illegal", 64'(req_cyc - rq0), 64'd0);
    chk(lk_rd - lr0 == (amo && legal ? 1 : 0) && lk_wr - lw0 == (amo && legal ? 1 : 0),
        "R7 locked read and write count", 64'((lk_rd - lr0) * 16 + (lk_wr - lw0)),
        64'(amo && legal ? 17 : 0));
  endtask

  initial begin
    for (int k = 0; k < 256; k++) refm[k] = init_byte(k);
    repeat (3) @(negedge clk);
    chk(!out_valid && !mem_req && !mem_lock && in_ready, "R1 reset state",
        {60'd0, out_valid, mem_req, mem_lock, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !mem_req && !mem_lock && in_ready, "R1 after reset",
        {60'd0, out_valid, mem_req, mem_lock, in_ready}, 64'h1);

    // R2: sweep every opcode encoding
    for (int op = 0; op < 256; op++)
      run_op(8'(op), 64'h40, 64'h48, 16'h0000, 32'd0, op % 3);
    run_op(8'hDB, 64'h40, 64'h5, 16'h0, 32'h1, 1);   // R2: atomic with non-add immediate
    run_op(8'hC3, 64'h40, 64'h5, 16'h0, 32'h0, 0);   // R2: atomic word form with immediate 0

    // R3 R4 R5 R6 R7 R8: each size at every byte offset, negative displacement, high base bits
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 8; lo++)
        for (int kd = 0; kd < 4; kd++) begin
          int it, tgt;
          logic [63:0] base, v;
          logic [7:0] op;
          it   = sz * 32 + lo * 4 + kd;
          tgt  = 8 * ((it * 7) % 32) + lo;
          base = 64'h1234_5600_0000_0000 + 64'(tgt + 100);
          v    = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(it) * 64'h0101_0101_0101_0101);
          op   = {3'd3, 2'(sz), 3'd3};
          case (kd)
            0: run_op(op, base, v, 16'hFF9C, 32'd0, it % 3);                         // R4
            1: run_op({3'd3, 2'(sz), 3'd2}, base, v, 16'hFF9C, 32'h8000_00F1 ^ 32'(it), it % 3); // R5
            2: run_op({3'd3, 2'(sz), 3'd1}, 64'h0, base, 16'hFF9C, 32'd0, it % 3);  // R6
            default: run_op({3'd6, 2'(sz), 3'd3}, base, v, 16'hFF9C, 32'd0, it % 3); // R7
          endcase
        end
    run_op(8'hDB, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 32'd0, 2); // R7 carry wrap, double word
    run_op(8'hC3, 64'h18, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 32'd0, 0); // R7 carry wrap, word

    // R4 R5 R7: read the whole memory back through double-word loads
    for (int w = 0; w < 32; w++)
      run_op(8'h79, 64'h0, 64'(8 * w), 16'h0, 32'd0, w % 2);

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule